// File: doc/BRIEF.md
# Shared-Bus Asynchronous SRAM Access Controller

This block runs single 32-bit accesses on an asynchronous static RAM that shares its address and data wires with a flash bank. A host presents an address, a write flag, write data and a four-bit byte enable together with a request strobe. The controller then walks the memory through a setup phase, a strobe phase and a hold phase, and answers with a one-cycle done pulse. On a read, the returned word is presented alongside that pulse.

Every memory timing minimum is a nanosecond parameter. It is turned into a whole number of clock cycles by rounding up against the clock period. The data pins are given as an output value, an output enable and an input value, so the pad ring can build the three-state buffer. The flash select output is held inactive for as long as the block exists, so the shared bus can never have two devices selected. Each byte lane has its own active-low write strobe, and all four lanes share one address.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, and whenever no access is running, the SRAM select, output enable and all four write strobes are high (inactive), the data output enable is 0, ready is 1 and done is 0.
- R2: The flash select output is 1 in every cycle, including every cycle in which the SRAM select is low.
- R3: A write keeps the SRAM select low and drives the data bus from the first setup cycle to the last hold cycle. The address stays stable for that whole time. Each enabled lane strobe is low for at least the write strobe length: max(ceil(20 ns / period), ceil(15 ns / period)) cycles, which is 1 at 50 MHz. The strobe is low only after at least ceil(3 ns / period) setup cycles.
- R4: Write strobe bit i (bit 0 = data bits 7:0, bit 3 = data bits 31:24) goes low only when byte enable bit i is 1. Memory bytes in disabled lanes keep their old contents.
- R5: A read holds the output enable low for max(ceil(25 ns / period), ceil(15 ns / period)) cycles, which is 2 at 50 MHz. During that time the write strobes are high and the data bus is not driven. The word on the data input during the last such cycle is returned on the read data output with done.
- R6: The controller's data output enable is 0 in the cycle before the SRAM output enable falls and in every cycle the output enable is low.
- R7: Done rises setup + strobe + hold + 1 cycles after the accepting clock edge. The hold length is max(1, ceil(25 ns / period) - setup - strobe). At 50 MHz this gives 4 cycles for a write and 5 for a read.
- R8: Ready falls on the clock edge that accepts a request and stays low until done. A request held high while ready is low is not started, and it does not touch the memory.
- R9: Done is high for exactly one cycle, and ready is 1 again in the cycle after done.
- R10: A write with byte enable 0 runs the full write sequence with the normal latency, but no lane strobe goes low and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when ready_o is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Word address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables, bit i for data bits 8i+7:8i |
| ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with done_o after a read |
| mem_addr_o | output | 19 | Shared memory address bus |
| mem_dq_o | output | 32 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus output enable (1 = controller drives) |
| mem_dq_i | input | 32 | Data bus input value |
| sram_cs_n_o | output | 1 | SRAM select, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 4 | Per-lane SRAM write strobes, active low |
| flash_cs_n_o | output | 1 | Flash select, held high |

## Verification
The assertions take for granted that reset is applied before the first request, and that request fields are meaningful only in the cycle where ready is 1. The checker never looks at the host fields while the controller is busy. Stimulus changes inputs only on the falling clock edge. The busy-hold scenario deliberately keeps the request high with a different address and write flag to show that these are ignored. The memory model drives the data input only while select and output enable are low and every write strobe is high, so the returned word always comes from a real read phase.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } sbc_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Hold phase that stretches the access to at least the cycle time.
  function automatic int unsigned hold_cyc(input int unsigned wc, input int unsigned su,
                                           input int unsigned stb);
    return (wc > su + stb) ? (wc - su - stb) : 1;
  endfunction

endpackage

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WSTB_CYC  = 1,
  parameter int unsigned RSTB_CYC  = 2,
  parameter int unsigned WHOLD_CYC = 1,
  parameter int unsigned RHOLD_CYC = 1,
  parameter int unsigned CNT_W     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       wr_i,
  output sbc_state_e state_o,
  output logic       op_wr_o,
  output logic       accept_o,
  output logic       strobe_last_o,
  output logic       ready_o
);

  sbc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             op_wr_q;
  logic             phase_last;

  assign ready_o       = (state_q == ST_IDLE);
  assign accept_o      = ready_o && req_i;
  assign phase_last    = (cnt_q == '0);
  assign strobe_last_o = (state_q == ST_STROBE) && phase_last;
  assign state_o       = state_q;
  assign op_wr_o       = op_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_wr_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_SETUP;
            cnt_q   <= CNT_W'(SETUP_CYC - 1);
            op_wr_q <= wr_i;
          end
        end
        ST_SETUP: begin
          if (phase_last) begin
            state_q <= ST_STROBE;
            cnt_q   <= op_wr_q ? CNT_W'(WSTB_CYC - 1) : CNT_W'(RSTB_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STROBE: begin
          if (phase_last) begin
            state_q <= ST_HOLD;
            cnt_q   <= op_wr_q ? CNT_W'(WHOLD_CYC - 1) : CNT_W'(RHOLD_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: begin
          if (phase_last) begin
            state_q <= ST_DONE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbc_pins.sv
module sbc_pins
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbc_state_e        state_i,
  input  logic              op_wr_i,
  input  logic              accept_i,
  input  logic              strobe_last_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic [LANES-1:0]  we_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q;
  logic              selected;
  logic              wr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (strobe_last_i && !op_wr_i) begin
      rdata_q <= dq_i;
    end
  end

  assign selected  = (state_i == ST_SETUP) || (state_i == ST_STROBE) || (state_i == ST_HOLD);
  assign wr_strobe = (state_i == ST_STROBE) && op_wr_i;

  assign cs_n_o  = !selected;
  assign dq_oe_o = selected && op_wr_i;
  assign oe_n_o  = !((state_i == ST_STROBE) && !op_wr_i);
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = (state_i == ST_DONE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we_n_o[l] = !(wr_strobe && be_q[l]);
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned T_AS_NS = 3,
  parameter int unsigned T_WP_NS = 20,
  parameter int unsigned T_DW_NS = 15,
  parameter int unsigned T_WC_NS = 25,
  parameter int unsigned T_AA_NS = 25,
  parameter int unsigned T_OE_NS = 15,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              sram_cs_n_o,
  output logic              sram_oe_n_o,
  output logic [LANES-1:0]  sram_we_n_o,
  output logic              flash_cs_n_o
);

  localparam int unsigned SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned WSTB_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned RSTB_CYC  = max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WHOLD_CYC = hold_cyc(WC_CYC, SETUP_CYC, WSTB_CYC);
  localparam int unsigned RHOLD_CYC = hold_cyc(WC_CYC, SETUP_CYC, RSTB_CYC);
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, max2(WSTB_CYC, RSTB_CYC)),
                                           max2(WHOLD_CYC, RHOLD_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  sbc_state_e state;
  logic       op_wr;
  logic       accept;
  logic       strobe_last;
  logic       dq_drive;

  sbc_seq #(
    .SETUP_CYC(SETUP_CYC),
    .WSTB_CYC (WSTB_CYC),
    .RSTB_CYC (RSTB_CYC),
    .WHOLD_CYC(WHOLD_CYC),
    .RHOLD_CYC(RHOLD_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .wr_i         (wr_i),
    .state_o      (state),
    .op_wr_o      (op_wr),
    .accept_o     (accept),
    .strobe_last_o(strobe_last),
    .ready_o      (ready_o)
  );

  sbc_pins #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state),
    .op_wr_i      (op_wr),
    .accept_i     (accept),
    .strobe_last_i(strobe_last),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .be_i         (be_i),
    .dq_i         (mem_dq_i),
    .addr_o       (mem_addr_o),
    .dq_o         (mem_dq_o),
    .dq_oe_o      (dq_drive),
    .cs_n_o       (sram_cs_n_o),
    .oe_n_o       (sram_oe_n_o),
    .we_n_o       (sram_we_n_o),
    .rdata_o      (rdata_o),
    .done_o       (done_o)
  );

  assign mem_dq_oe_o  = dq_drive;
  assign flash_cs_n_o = 1'b1;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned LANES    = 4,
  parameter int unsigned WSTB_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              sram_cs_n_o,
  input logic              sram_oe_n_o,
  input logic [LANES-1:0]  sram_we_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              dq_drive
);

  logic       we_act;
  logic       we_act_q;
  logic [7:0] we_len_q;

  assign we_act = (sram_we_n_o != {LANES{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_act_q <= 1'b0;
      we_len_q <= '0;
    end else begin
      we_act_q <= we_act;
      if (!we_act) we_len_q <= '0;
      else if (we_len_q != 8'hFF) we_len_q <= we_len_q + 1'b1;
    end
  end

  p_bus_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n_o |-> !dq_drive);

  p_we_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_act |-> (!sram_cs_n_o && dq_drive && sram_oe_n_o));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n_o && $past(!sram_cs_n_o)) |-> $stable(mem_addr_o));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_act_q && !we_act) |-> (we_len_q >= 8'(WSTB_CYC)));

  p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n_o |-> (!dq_drive && !we_act && !sram_cs_n_o));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n_o) |-> !$past(dq_drive));

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_i) |=> !ready_o);

  p_busy_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ready_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && ready_o));

endmodule

bind sram_bus_ctrl sbc_checker #(
  .ADDR_W  (ADDR_W),
  .LANES   (LANES),
  .WSTB_CYC(WSTB_CYC)
) u_sbc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .sram_cs_n_o(sram_cs_n_o),
  .sram_oe_n_o(sram_oe_n_o),
  .sram_we_n_o(sram_we_n_o),
  .mem_addr_o (mem_addr_o),
  .dq_drive   (dq_drive)
);

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;

  localparam int CLK = 20;
  // Expected phase lengths, restated from the requirements.
  localparam int SU    = (3 + CLK - 1) / CLK;
  localparam int WSTB  = ((20 + CLK - 1) / CLK > (15 + CLK - 1) / CLK) ? (20 + CLK - 1) / CLK : (15 + CLK - 1) / CLK;
  localparam int RSTB  = ((25 + CLK - 1) / CLK > (15 + CLK - 1) / CLK) ? (25 + CLK - 1) / CLK : (15 + CLK - 1) / CLK;
  localparam int WC    = (25 + CLK - 1) / CLK;
  localparam int WHOLD = (WC - SU - WSTB > 1) ? WC - SU - WSTB : 1;
  localparam int RHOLD = (WC - SU - RSTB > 1) ? WC - SU - RSTB : 1;
  localparam int WLAT  = SU + WSTB + WHOLD + 1;
  localparam int RLAT  = SU + RSTB + RHOLD + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        ready, done, dq_oe, cs_n, oe_n, fl_cs_n;
  logic [31:0] rdata, dq_o, dq_i;
  logic [18:0] maddr;
  logic [3:0]  we_n;

  logic [31:0] mem [0:63];

  int vectors = 0, miscompares = 0;
  int r_lat, r_oe_cnt, r_cs_cnt, r_we_cnt[4];
  int r_addr_bad, r_fl_bad, r_turn_bad, r_ready_bad, r_early_we;
  logic [31:0] r_rd;

  always #(CLK / 2) clk = ~clk;

  sram_bus_ctrl i_sram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .ready_o(ready), .done_o(done), .rdata_o(rdata), .mem_addr_o(maddr),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i), .sram_cs_n_o(cs_n),
    .sram_oe_n_o(oe_n), .sram_we_n_o(we_n), .flash_cs_n_o(fl_cs_n)
  );

  // Asynchronous SRAM model: reads only in a true read phase.
  assign dq_i = (!cs_n && !oe_n && (&we_n)) ? mem[maddr[5:0]] : 32'h0;
  always @(posedge clk)
    for (int l = 0; l < 4; l++)
      if (!cs_n && !we_n[l]) mem[maddr[5:0]][l*8 +: 8] <= dq_o[l*8 +: 8];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Runs one access and gathers its per-cycle trace at falling edges.
  task automatic access(input bit w, input logic [18:0] a, input logic [31:0] d,
                        input logic [3:0] b, input bit hold_req);
    int  n = 0;
    bit  prev_drive = 0, oe_seen = 0;
    r_lat = 0; r_oe_cnt = 0; r_cs_cnt = 0; r_addr_bad = 0; r_fl_bad = 0;
    r_turn_bad = 0; r_ready_bad = 0; r_early_we = 0;
    for (int l = 0; l < 4; l++) r_we_cnt[l] = 0;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; be = b;
    while (r_lat == 0 && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (hold_req) begin
          addr = a + 19'd1; wr = ~w; wdata = ~d; be = 4'hF;
        end else req = 1'b0;
      end
      if (!fl_cs_n) r_fl_bad++;
      if (!cs_n) begin
        r_cs_cnt++;
        if (maddr !== a) r_addr_bad++;
      end
      for (int l = 0; l < 4; l++) if (!we_n[l]) r_we_cnt[l]++;
      if (!(&we_n) && n <= SU) r_early_we++;
      if (!oe_n) begin
        r_oe_cnt++;
        if ((!oe_seen && prev_drive) || dq_oe) r_turn_bad++;
        oe_seen = 1;
      end
      if (ready && !done) r_ready_bad++;
      prev_drive = dq_oe;
      if (done) begin
        r_lat = n; r_rd = rdata;
        if (ready) r_ready_bad++;
      end
    end
    req = 1'b0;
  endtask

  task automatic t_after_done;
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 32'(done), 0);
    chk(ready == 1'b1, "R9 ready after done", 32'(ready), 1);
    chk(cs_n == 1'b1 && dq_oe == 1'b0, "R1 idle after access", {cs_n, dq_oe}, 32'h2);
  endtask

  task automatic t_reset;
    chk(cs_n && oe_n && (we_n == 4'hF), "R1 strobes idle", {cs_n, oe_n, we_n}, 32'h3F);
    chk(dq_oe == 1'b0, "R1 bus released", 32'(dq_oe), 0);
    chk(ready == 1'b1 && done == 1'b0, "R1 ready/done", {ready, done}, 32'h2);
    chk(fl_cs_n == 1'b1, "R2 flash idle at reset", 32'(fl_cs_n), 1);
  endtask

  task automatic t_write_read(input logic [18:0] a, input logic [31:0] d);
    access(1'b1, a, d, 4'hF, 1'b0);
    chk(r_lat == WLAT, "R7 write latency", r_lat, WLAT);
    for (int l = 0; l < 4; l++)
      chk(r_we_cnt[l] == WSTB, "R3 lane strobe length", r_we_cnt[l], WSTB);
    chk(r_early_we == 0, "R3 strobe after setup", r_early_we, 0);
    chk(r_addr_bad == 0, "R3 address stable", r_addr_bad, 0);
    chk(r_fl_bad == 0, "R2 flash high during write", r_fl_bad, 0);
    chk(r_ready_bad == 0, "R8 ready low while busy", r_ready_bad, 0);
    t_after_done();
    access(1'b0, a, 32'h0, 4'h0, 1'b0);
    chk(r_lat == RLAT, "R7 read latency", r_lat, RLAT);
    chk(r_rd == d, "R5 read data", r_rd, d);
    chk(r_oe_cnt == RSTB, "R5 output enable length", r_oe_cnt, RSTB);
    chk(r_we_cnt[0] + r_we_cnt[1] + r_we_cnt[2] + r_we_cnt[3] == 0, "R5 no strobe on read",
        r_we_cnt[0], 0);
    chk(r_turn_bad == 0, "R6 bus turnaround", r_turn_bad, 0);
    chk(r_fl_bad == 0, "R2 flash high during read", r_fl_bad, 0);
    t_after_done();
  endtask

  task automatic t_byte_mask;
    access(1'b1, 19'd9, 32'h11223344, 4'hF, 1'b0);
    t_after_done();
    access(1'b1, 19'd9, 32'hAABBCCDD, 4'b0101, 1'b0);
    chk(r_we_cnt[1] == 0 && r_we_cnt[3] == 0, "R4 disabled lanes quiet",
        r_we_cnt[1] + r_we_cnt[3], 0);
    chk(r_we_cnt[0] == WSTB && r_we_cnt[2] == WSTB, "R4 enabled lanes strobe",
        r_we_cnt[0] + r_we_cnt[2], 2 * WSTB);
    t_after_done();
    access(1'b0, 19'd9, 32'h0, 4'h0, 1'b0);
    chk(r_rd == 32'h11BB33DD, "R4 masked merge", r_rd, 32'h11BB33DD);
    t_after_done();
  endtask

  task automatic t_empty_mask;
    access(1'b1, 19'd20, 32'h5A5A5A5A, 4'hF, 1'b0);
    t_after_done();
    access(1'b1, 19'd20, 32'hFFFFFFFF, 4'h0, 1'b0);
    chk(r_lat == WLAT, "R10 empty mask latency", r_lat, WLAT);
    chk(r_cs_cnt == WLAT - 1, "R10 select still pulses", r_cs_cnt, WLAT - 1);
    chk(r_we_cnt[0] + r_we_cnt[1] + r_we_cnt[2] + r_we_cnt[3] == 0, "R10 no strobe",
        r_we_cnt[0], 0);
    t_after_done();
    access(1'b0, 19'd20, 32'h0, 4'h0, 1'b0);
    chk(r_rd == 32'h5A5A5A5A, "R10 memory unchanged", r_rd, 32'h5A5A5A5A);
    t_after_done();
  endtask

  task automatic t_busy_hold;
    access(1'b1, 19'd13, 32'h13131313, 4'hF, 1'b0);
    t_after_done();
    access(1'b1, 19'd12, 32'hC0FFEE12, 4'hF, 1'b1);
    chk(r_lat == WLAT, "R8 held request latency", r_lat, WLAT);
    chk(r_ready_bad == 0, "R8 ready low until done", r_ready_bad, 0);
    chk(r_addr_bad == 0, "R8 address not replaced", r_addr_bad, 0);
    t_after_done();
    access(1'b0, 19'd13, 32'h0, 4'h0, 1'b0);
    chk(r_rd == 32'h13131313, "R8 held request ignored", r_rd, 32'h13131313);
    t_after_done();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read(19'd5, 32'hA5A51234);
    t_write_read(19'd63, 32'h00FF00FF);
    t_write_read(19'h7FFC0, 32'hDEADBEEF);
    t_byte_mask();
    t_empty_mask();
    t_busy_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule